// File: doc/BRIEF.md
# Debug Breakpoint and Halt Controller

This block is the decision core of an on-chip debug unit for a small processor. A host debugger writes a control word that turns breakpoints on or off, selects what a breakpoint does, requests single steps and keeps the system clock alive through low-power stop mode. The control word also reads back as a status word.

Breakpoint events come from two sources: a software break instruction decoded by the CPU, and a hit reported by an external hardware address comparator. Each event is routed one of three ways. It can raise an illegal-instruction trap. It can make the CPU repeat its current instruction. It can put the CPU into debug halt.

While the CPU is halted, the host can grant exactly one instruction. The CPU side sees a run/hold level, a repeat pulse and a trap pulse. It returns an instruction-retired pulse.

Top module: `dbg_halt_ctl`

## Requirements
- R1: After reset the read-back word is 0, `cpu_run` is 1, `halted` is 0 and `trap_req` and `cpu_repeat` are 0.
- R2: With the enable bit (bit 3) at 0, a break instruction or a hardware hit sets `trap_req` on the next cycle. `halted` and `cpu_repeat` do not change.
- R3: With enable at 1 and the halt-on-break bit (bit 4) at 1, either event sets `halted` (bit 5) on the next cycle, and `cpu_run` drops to 0.
- R4: With enable at 1 and halt-on-break at 0, either event sets `cpu_repeat` on the next cycle. `halted` stays 0.
- R5: `trap_req` and `cpu_repeat` are single-cycle pulses and are never high together.
- R6: Writing the step bit (bit 0) as 1, together with halt bit 1, while halted sets step and raises `cpu_run`. On the cycle after an `insn_retired` pulse, step reads 0, `halted` stays 1 and `cpu_run` is 0.
- R7: A step write while the CPU is not halted is ignored: step reads 0 and `cpu_run` stays 1.
- R8: Debug halt persists until a host write puts bit 5 at 0.
- R9: `sys_clk_en` is 0 only while `stop_mode` is 1 and the stop-keep bit (bit 2) is 0.
- R10: The reserved bit (bit 1) has no effect and always reads 0.
- R11: The read-back word is {2'b00, halt, halt-on-break, enable, stop-keep, 0, step}.
- R12: A halting breakpoint and a host write that clears bit 5 in the same cycle leave the CPU halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the control word |
| host_wdata | input | CTRL_W | Control word written by the host |
| ctrl_rd | output | CTRL_W | Control/status read-back |
| brk_insn | input | 1 | CPU decoded a break instruction |
| hw_brk_hit | input | 1 | Hardware address comparator hit |
| insn_retired | input | 1 | CPU retired one instruction (pulse) |
| stop_mode | input | 1 | CPU is in low-power stop mode |
| cpu_run | output | 1 | 1 lets the CPU advance, 0 holds it |
| cpu_repeat | output | 1 | Pulse: re-execute the current instruction |
| trap_req | output | 1 | Pulse: raise an illegal-instruction trap |
| halted | output | 1 | CPU is in debug halt |
| sys_clk_en | output | 1 | System clock enable |

## Verification
Every registered result is due one clock edge after its stimulus. This covers the trap pulse, the repeat pulse, the halt bit, the step bit and the read-back word. `cpu_run` and `sys_clk_en` follow those registers combinationally, so `cpu_run` is due in that same cycle. `sys_clk_en` changes in the same cycle as `stop_mode`.

The bench drives inputs one time unit after a rising edge and samples one time unit after the next. Every check therefore lands on the first cycle where the result is due. The pulse checks then look one further cycle ahead to confirm the output has dropped again.

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [CTRL_W-1:0] host_wdata,
  output logic [CTRL_W-1:0] ctrl_rd,
  input  logic              brk_insn,
  input  logic              hw_brk_hit,
  input  logic              insn_retired,
  input  logic              stop_mode,
  output logic              cpu_run,
  output logic              cpu_repeat,
  output logic              trap_req,
  output logic              halted,
  output logic              sys_clk_en
);

  localparam int B_STEP  = 0;
  localparam int B_STOPK = 2;
  localparam int B_EN    = 3;
  localparam int B_BH    = 4;
  localparam int B_HALT  = 5;

  logic step_q, stopk_q, en_q, bh_q, halt_q, trap_q, rep_q;

  wire brk_evt  = brk_insn | hw_brk_hit;
  wire evt_trap = brk_evt & ~en_q;
  wire evt_halt = brk_evt & en_q & bh_q;
  wire evt_loop = brk_evt & en_q & ~bh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= 1'b0;
      stopk_q <= 1'b0;
      en_q    <= 1'b0;
      bh_q    <= 1'b0;
      halt_q  <= 1'b0;
      trap_q  <= 1'b0;
      rep_q   <= 1'b0;
    end else begin
      trap_q <= evt_trap;
      rep_q  <= evt_loop;
      if (host_wr) begin
        stopk_q <= host_wdata[B_STOPK];
        en_q    <= host_wdata[B_EN];
        bh_q    <= host_wdata[B_BH];
        halt_q  <= host_wdata[B_HALT] | evt_halt;
        step_q  <= host_wdata[B_STEP] & host_wdata[B_HALT] & halt_q;
      end else begin
        if (evt_halt)
          halt_q <= 1'b1;
        if (step_q && insn_retired)
          step_q <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[B_STEP]  = step_q;
    ctrl_rd[B_STOPK] = stopk_q;
    ctrl_rd[B_EN]    = en_q;
    ctrl_rd[B_BH]    = bh_q;
    ctrl_rd[B_HALT]  = halt_q;
  end

  assign cpu_run    = ~halt_q | step_q;
  assign halted     = halt_q;
  assign trap_req   = trap_q;
  assign cpu_repeat = rep_q;
  assign sys_clk_en = ~stop_mode | stopk_q;

  assert_trap_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(brk_evt && !en_q));

  assert_halt_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_q) |-> $past(evt_halt || (host_wr && host_wdata[B_HALT])));

  assert_repeat_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_repeat |-> $past(brk_evt && en_q && !bh_q));

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_req, cpu_repeat}));

  assert_step_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && insn_retired && !host_wr) |=> (!step_q && halt_q && !cpu_run));

  assert_step_needs_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |-> halt_q);

  assert_halt_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_q) |-> $past(host_wr && !host_wdata[B_HALT]));

endmodule

// File: tb/dbg_halt_ctl_bench.sv
module dbg_halt_ctl_bench;
  localparam int CTRL_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [CTRL_W-1:0] host_wdata = '0;
  logic [CTRL_W-1:0] ctrl_rd;
  logic brk_insn = 1'b0, hw_brk_hit = 1'b0, insn_retired = 1'b0, stop_mode = 1'b0;
  logic cpu_run, cpu_repeat, trap_req, halted, sys_clk_en;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbg_halt_ctl #(.CTRL_W(CTRL_W)) u_dbg_halt_ctl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .ctrl_rd(ctrl_rd), .brk_insn(brk_insn), .hw_brk_hit(hw_brk_hit),
    .insn_retired(insn_retired), .stop_mode(stop_mode), .cpu_run(cpu_run),
    .cpu_repeat(cpu_repeat), .trap_req(trap_req), .halted(halted),
    .sys_clk_en(sys_clk_en)
  );

  // {en, halt_on_break, src_hw, exp_trap, exp_repeat, exp_halt}
  localparam logic [5:0] VEC [8] = '{
    6'b000_100, 6'b001_100, 6'b010_100, 6'b011_100,
    6'b100_010, 6'b101_010, 6'b110_001, 6'b111_001
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [CTRL_W-1:0] d);
    host_wr = 1'b1; host_wdata = d;
    tick();
    host_wr = 1'b0; host_wdata = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1", "ctrl_rd", ctrl_rd, 0);
    chk("R1", "cpu_run", cpu_run, 1);
    chk("R1", "halted", halted, 0);
    chk("R1", "pulses", {trap_req, cpu_repeat}, 0);
    rst_n = 1'b1;
    tick();

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      v = VEC[i];
      wr({3'b000, v[4], v[5], 3'b000});
      if (v[3]) hw_brk_hit = 1'b1; else brk_insn = 1'b1;
      tick();
      brk_insn = 1'b0; hw_brk_hit = 1'b0;
      chk("R2", "trap_req", trap_req, v[2]);
      chk("R4", "cpu_repeat", cpu_repeat, v[1]);
      chk("R3", "halted", halted, v[0]);
      chk("R3", "cpu_run", cpu_run, !v[0]);
      tick();
      chk("R5", "pulse drop", {trap_req, cpu_repeat}, 0);
      wr(8'h00);
      chk("R8", "halt cleared", halted, 0);
    end

    // R7 step ignored while running
    wr(8'h01);
    chk("R7", "step bit", ctrl_rd[0], 0);
    chk("R7", "cpu_run", cpu_run, 1);

    // R10 reserved bit
    wr(8'h02);
    chk("R10", "reserved readback", ctrl_rd, 0);

    // R11 layout
    wr(8'h1C);
    chk("R11", "readback", ctrl_rd, 8'h1C);

    // R9 clock keep-alive
    stop_mode = 1'b1; #1;
    chk("R9", "stop keep on", sys_clk_en, 1);
    wr(8'h00);
    chk("R9", "stop keep off", sys_clk_en, 0);
    stop_mode = 1'b0; #1;
    chk("R9", "running", sys_clk_en, 1);

    // R8 halt persists, R6 single step
    wr(8'h20);
    chk("R8", "halted", halted, 1);
    repeat (5) tick();
    chk("R8", "still halted", halted, 1);
    chk("R8", "cpu held", cpu_run, 0);
    wr(8'h21);
    chk("R6", "step set", ctrl_rd, 8'h21);
    chk("R6", "cpu_run step", cpu_run, 1);
    repeat (3) tick();
    chk("R6", "step waits", ctrl_rd[0], 1);
    insn_retired = 1'b1;
    tick();
    insn_retired = 1'b0;
    chk("R6", "step cleared", ctrl_rd[0], 0);
    chk("R6", "halted after", halted, 1);
    chk("R6", "cpu held after", cpu_run, 0);
    wr(8'h00);
    chk("R8", "exit halt", halted, 0);

    // R12 breakpoint halt beats clearing write
    wr(8'h18);
    host_wr = 1'b1; host_wdata = 8'h18; brk_insn = 1'b1;
    tick();
    host_wr = 1'b0; host_wdata = '0; brk_insn = 1'b0;
    chk("R12", "halted", halted, 1);
    wr(8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule